// File: doc/BRIEF.md
# Configuration Request Retry Controller

This block sits between a simple register-style configuration access port and the request/completion side of a root-complex bridge. Software (or a sequencer) presents one configuration read or write naming the bus, device, function and byte offset. The block packs these into a single address word, launches it as a request record and then waits for the completion. One access is in flight at a time, and a busy flag shows when the port is occupied.

When the completion carries the retry status, the hardware repeats the request on its own. It waits a programmable gap between attempts and gives up with a device-not-found code once a cycle budget has run out. If software visibility is enabled, a read of the vendor-ID dword that meets retry is answered at once with the synthetic value 0xFFFF0001, reported as a normal completion. Accesses to bus 0 are aimed at the root's own space and are never retried. Byte and halfword reads return the addressed lanes right-aligned and zero-extended.

Top module: `cfg_retry_ctrl`

## Requirements
- R1: The request address is packed as bus in bits 27:20, device in 19:15, function in 14:12, dword register number (offset bits 11:2) in 11:2, bit 1 zero, and bit 0 set to 1 exactly when the bus is not 0. Bits 31:28 are zero.
- R2: A request is accepted only while `busy` is low. `busy` stays high from acceptance until `done`. A `req_valid` seen while busy has no effect on the request record or on the result.
- R3: A completion status of 0 (success) ends the access with `rsp_status` 0. A read returns the extracted data and a write returns 0.
- R4: A completion status of 2 (retry) on a bus other than 0 makes the block issue the same request again. This applies to writes and to every read except the case in R6, whatever the visibility setting.
- R5: After a retry completion, at least `RETRY_GAP` cycles pass before the next request pulse.
- R6: With visibility enabled, a read whose offset bits 11:2 are all zero on a bus other than 0 that meets retry finishes after one attempt. It returns status 0, with data taken from 0xFFFF0001 as in R10.
- R7: A retry completion that arrives once `TIMEOUT_CYC` cycles have passed since acceptance ends the access with `rsp_status` 1 (device not found) and data 0.
- R8: On bus 0 a retry completion is never re-issued. It ends the access with `rsp_status` 3.
- R9: Any completion status other than 0 or 2 ends the access with `rsp_status` 2 and data 0.
- R10: Read data is shifted right by 8 times offset bits 1:0 and masked by `req_size`: 0 keeps 8 bits, 1 keeps 16 bits, 2 returns the whole dword unshifted.
- R11: `tx_valid` is a one-cycle pulse per attempt, rising two clock edges after acceptance. `done` is a one-cycle pulse one edge after the completion is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an access (taken when not busy) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_off | input | 12 | Byte offset in configuration space |
| req_size | input | 2 | 0 byte, 1 halfword, 2 dword |
| req_wdata | input | 32 | Write data |
| sw_vis_en | input | 1 | Retry software visibility enable |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 not found, 2 error, 3 root retry |
| rsp_data | output | 32 | Read result |
| tx_valid | output | 1 | Request pulse |
| tx_write | output | 1 | Request is a write |
| tx_addr | output | 32 | Packed request address |
| tx_wdata | output | 32 | Request write data |
| cpl_valid | input | 1 | Completion present |
| cpl_status | input | 3 | Completion status (2 = retry) |
| cpl_data | input | 32 | Completion data |

## Verification
The first request pulse appears two edges after acceptance, and `done` follows one edge after the completion that ends the access. Each retry adds the gap and the endpoint latency before the next pulse. The bench samples on falling edges, polls for the `done` pulse rather than assuming a cycle count, and reads the result in that cycle. Spacing between a retry completion and the next pulse is timed in the bench's endpoint model. The timeout result is bounded between the budget and the budget plus one attempt period.

// File: rtl/cfg_retry_pkg.sv
package cfg_retry_pkg;

  localparam logic [2:0]  CPL_OK        = 3'd0;
  localparam logic [2:0]  CPL_RETRY     = 3'd2;
  localparam logic [31:0] VIS_VENDOR_DW = 32'hFFFF_0001;

  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_NOTFOUND = 2'd1,
    RSP_ERROR    = 2'd2,
    RSP_ROOTCRS  = 2'd3
  } rsp_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_GAP
  } ctl_state_e;

  typedef struct packed {
    logic        wr;
    logic [7:0]  bus;
    logic [11:0] off;
    logic [1:0]  size;
    logic        vis;
  } held_req_t;

endpackage

// File: rtl/cfg_addr_pack.sv
module cfg_addr_pack (
  input  logic [7:0]  bus,
  input  logic [4:0]  dev,
  input  logic [2:0]  fn,
  input  logic [9:0]  dw_num,
  output logic [31:0] addr
);
  logic below_root;

  always_comb begin
    below_root = (bus != 8'd0);
    addr       = {4'd0, bus, dev, fn, dw_num, 1'b0, below_root};
  end
endmodule

// File: rtl/cfg_lane_extract.sv
module cfg_lane_extract (
  input  logic [31:0] dword,
  input  logic [1:0]  lane,
  input  logic [1:0]  size,
  output logic [31:0] result
);
  logic [31:0] shifted;

  always_comb begin
    shifted = dword >> {lane, 3'b000};
    case (size)
      2'd0:    result = {24'd0, shifted[7:0]};
      2'd1:    result = {16'd0, shifted[15:0]};
      default: result = dword;
    endcase
  end
endmodule

// File: rtl/cfg_retry_timer.sv
module cfg_retry_timer #(
  parameter int RETRY_GAP   = 100,
  parameter int TIMEOUT_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic gap_load,
  output logic expired,
  output logic gap_zero
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int GW = (RETRY_GAP > 1) ? $clog2(RETRY_GAP + 1) : 1;

  logic [TW-1:0] elapsed;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
    end else if (start) begin
      elapsed <= '0;
    end else if (run && !expired) begin
      elapsed <= elapsed + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
    end else if (gap_load) begin
      gap_cnt <= GW'(RETRY_GAP - 1);
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - GW'(1);
    end
  end

  assign expired  = (elapsed >= TW'(TIMEOUT_CYC));
  assign gap_zero = (gap_cnt == '0);
endmodule

// File: rtl/cfg_retry_ctrl.sv
module cfg_retry_ctrl #(
  parameter int RETRY_GAP   = 100,
  parameter int TIMEOUT_CYC = 50_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_bus,
  input  logic [4:0]  req_dev,
  input  logic [2:0]  req_func,
  input  logic [11:0] req_off,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  input  logic        sw_vis_en,
  output logic        busy,
  output logic        done,
  output logic [1:0]  rsp_status,
  output logic [31:0] rsp_data,
  output logic        tx_valid,
  output logic        tx_write,
  output logic [31:0] tx_addr,
  output logic [31:0] tx_wdata,
  input  logic        cpl_valid,
  input  logic [2:0]  cpl_status,
  input  logic [31:0] cpl_data
);
  import cfg_retry_pkg::*;

  ctl_state_e  state;
  held_req_t   held;
  logic [31:0] packed_addr;
  logic [31:0] lane_src;
  logic [31:0] lane_out;
  logic        accept;
  logic        below_root;
  logic        vendor_vis;
  logic        is_retry;
  logic        gap_load;
  logic        expired;
  logic        gap_zero;

  cfg_addr_pack pack_i (
    .bus    (req_bus),
    .dev    (req_dev),
    .fn     (req_func),
    .dw_num (req_off[11:2]),
    .addr   (packed_addr)
  );

  always_comb begin
    accept     = (state == ST_IDLE) && req_valid;
    below_root = (held.bus != 8'd0);
    vendor_vis = !held.wr && held.vis && below_root && (held.off[11:2] == 10'd0);
    is_retry   = (cpl_status == CPL_RETRY);
    gap_load   = (state == ST_WAIT) && cpl_valid && is_retry && below_root
                 && !vendor_vis && !expired;
    lane_src   = (is_retry && vendor_vis) ? VIS_VENDOR_DW : cpl_data;
  end

  cfg_lane_extract lane_i (
    .dword  (lane_src),
    .lane   (held.off[1:0]),
    .size   (held.size),
    .result (lane_out)
  );

  cfg_retry_timer #(
    .RETRY_GAP   (RETRY_GAP),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .run      (state != ST_IDLE),
    .gap_load (gap_load),
    .expired  (expired),
    .gap_zero (gap_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      held       <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      rsp_status <= RSP_OK;
      rsp_data   <= '0;
      tx_valid   <= 1'b0;
      tx_write   <= 1'b0;
      tx_addr    <= '0;
      tx_wdata   <= '0;
    end else begin
      done     <= 1'b0;
      tx_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            held.wr   <= req_write;
            held.bus  <= req_bus;
            held.off  <= req_off;
            held.size <= req_size;
            held.vis  <= sw_vis_en;
            tx_write  <= req_write;
            tx_addr   <= packed_addr;
            tx_wdata  <= req_wdata;
            busy      <= 1'b1;
            state     <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          tx_valid <= 1'b1;
          state    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cpl_valid) begin
            if (gap_load) begin
              state <= ST_GAP;
            end else begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= ST_IDLE;
              if (cpl_status == CPL_OK || (is_retry && vendor_vis)) begin
                rsp_status <= RSP_OK;
                rsp_data   <= held.wr ? 32'd0 : lane_out;
              end else if (is_retry && !below_root) begin
                rsp_status <= RSP_ROOTCRS;
                rsp_data   <= '0;
              end else if (is_retry) begin
                rsp_status <= RSP_NOTFOUND;
                rsp_data   <= '0;
              end else begin
                rsp_status <= RSP_ERROR;
                rsp_data   <= '0;
              end
            end
          end
        end
        ST_GAP: begin
          if (gap_zero) state <= ST_ISSUE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_retry_ctrl_chk.sv
module cfg_retry_ctrl_chk #(
  parameter int RETRY_GAP = 100
) (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic [1:0]  rsp_status,
  input logic        tx_valid,
  input logic [31:0] tx_addr,
  input logic        cpl_valid,
  input logic [2:0]  cpl_status
);
  logic [31:0] since_retry;
  logic        retry_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_retry <= '0;
      retry_pend  <= 1'b0;
    end else begin
      if (cpl_valid && cpl_status == 3'd2) begin
        retry_pend  <= 1'b1;
        since_retry <= '0;
      end else begin
        if (since_retry != 32'hFFFF_FFFF) since_retry <= since_retry + 32'd1;
        if (tx_valid || done) retry_pend <= 1'b0;
      end
    end
  end

  a_r11_tx_single: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);

  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_tx_while_busy: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> busy);

  a_r2_addr_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(tx_addr));

  a_r1_type_bit: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_addr[0] == (tx_addr[27:20] != 8'd0)));

  a_r5_retry_gap: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && retry_pend) |-> (since_retry >= 32'(RETRY_GAP)));

  a_r6_no_root_code_below: assert property (@(posedge clk) disable iff (rst)
    (done && tx_addr[0]) |-> (rsp_status != 2'd3));

  a_r3_done_follows_cpl: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(cpl_valid));
endmodule

bind cfg_retry_ctrl cfg_retry_ctrl_chk #(.RETRY_GAP(RETRY_GAP)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .rsp_status (rsp_status),
  .tx_valid   (tx_valid),
  .tx_addr    (tx_addr),
  .cpl_valid  (cpl_valid),
  .cpl_status (cpl_status)
);

// File: tb/cfg_retry_ctrl_tb.sv
module cfg_retry_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 4;
  localparam int TMO        = 200;
  localparam int LAT        = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [11:0] req_off = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        sw_vis_en = 1'b0;
  logic        busy, done, tx_valid, tx_write;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_data, tx_addr, tx_wdata;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;

  int checks = 0;
  int fails  = 0;

  cfg_retry_ctrl #(.RETRY_GAP(GAP), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
    .req_size(req_size), .req_wdata(req_wdata), .sw_vis_en(sw_vis_en),
    .busy(busy), .done(done), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .tx_valid(tx_valid), .tx_write(tx_write), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
    .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // endpoint model
  int          cyc = 0;
  int          issues = 0;
  int          crs_cfg = 0;
  int          crs_used = 0;
  logic [2:0]  ep_stat = 3'd0;
  logic        pend = 1'b0;
  int          lat_cnt = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] last_wdata = '0;
  logic        last_wr = 1'b0;
  int          t_retry = 0;
  logic        have_retry = 1'b0;
  int          min_gap = 1000000;

  function automatic logic [31:0] ep_data(input logic [31:0] a);
    return (a ^ 32'h5A5A_3C3C) + {a[15:0], a[31:16]};
  endfunction

  always @(posedge clk) begin
    cyc       <= cyc + 1;
    cpl_valid <= 1'b0;
    if (done) crs_used <= 0;
    if (tx_valid) begin
      pend       <= 1'b1;
      lat_cnt    <= LAT;
      issues     <= issues + 1;
      last_addr  <= tx_addr;
      last_wr    <= tx_write;
      last_wdata <= tx_wdata;
      if (have_retry && (cyc - t_retry) < min_gap) min_gap <= cyc - t_retry;
      have_retry <= 1'b0;
    end else if (pend) begin
      if (lat_cnt == 0) begin
        pend      <= 1'b0;
        cpl_valid <= 1'b1;
        cpl_data  <= ep_data(last_addr);
        if (crs_used < crs_cfg) begin
          cpl_status <= 3'd2;
          crs_used   <= crs_used + 1;
          t_retry    <= cyc;
          have_retry <= 1'b1;
        end else begin
          cpl_status <= ep_stat;
        end
      end else begin
        lat_cnt <= lat_cnt - 1;
      end
    end
    if (done) have_retry <= 1'b0;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [7:0] b, input logic [4:0] d,
                                           input logic [2:0] f, input logic [11:0] o);
    return {4'd0, b, d, f, o[11:2], 1'b0, (b != 8'd0)};
  endfunction

  function automatic logic [31:0] exp_lane(input logic [31:0] dw, input logic [1:0] o,
                                           input logic [1:0] sz);
    logic [31:0] s;
    s = dw >> (8 * o);
    if (sz == 2'd0) return s & 32'h0000_00FF;
    if (sz == 2'd1) return s & 32'h0000_FFFF;
    return dw;
  endfunction

  logic [1:0]  g_status;
  logic [31:0] g_data;
  int          g_issues;
  int          g_cycles;

  task automatic run_req(input logic wr, input logic [7:0] b, input logic [4:0] d,
                         input logic [2:0] f, input logic [11:0] o, input logic [1:0] sz,
                         input logic [31:0] wd, input logic vis, input int ncrs,
                         input logic [2:0] est);
    int i0;
    int n;
    @(negedge clk);
    crs_cfg   = ncrs;
    ep_stat   = est;
    req_valid = 1'b1;
    req_write = wr; req_bus = b; req_dev = d; req_func = f;
    req_off = o; req_size = sz; req_wdata = wd; sw_vis_en = vis;
    i0 = issues;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check(1'b0, "watchdog R11", 32'(n), 32'd5000);
    g_status = rsp_status;
    g_data   = rsp_data;
    g_issues = issues - i0;
    g_cycles = n;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check(!busy && !done && !tx_valid, "R2 reset idle", {29'd0, busy, done, tx_valid}, 32'd0);
    check(rsp_status == 2'd0, "R3 reset status", 32'(rsp_status), 32'd0);

    // R10 / R4 / R1 sweep of size, lane and retry count on reads
    for (int sz = 0; sz < 3; sz++)
      for (int o = 0; o < 4; o++)
        for (int nc = 0; nc < 3; nc++) begin
          logic [11:0] off;
          off = 12'h040 + 12'(o) + 12'(nc * 16);
          run_req(1'b0, 8'd3, 5'd5, 3'd2, off, 2'(sz), 32'd0, 1'b0, nc, 3'd0);
          check(g_status == 2'd0, "R3 read ok", 32'(g_status), 32'd0);
          check(g_data == exp_lane(ep_data(exp_addr(8'd3, 5'd5, 3'd2, off)), 2'(o), 2'(sz)),
                "R10 lane data", g_data,
                exp_lane(ep_data(exp_addr(8'd3, 5'd5, 3'd2, off)), 2'(o), 2'(sz)));
          check(g_issues == nc + 1, "R4 read reissue count", 32'(g_issues), 32'(nc + 1));
          check(last_addr == exp_addr(8'd3, 5'd5, 3'd2, off), "R1 packed addr",
                last_addr, exp_addr(8'd3, 5'd5, 3'd2, off));
        end

    // R1 address fields over several buses/devices
    for (int k = 1; k < 6; k++) begin
      run_req(1'b0, 8'(k * 37), 5'(k * 7), 3'(k), 12'(k * 300), 2'd2, 32'd0, 1'b0, 0, 3'd0);
      check(last_addr == exp_addr(8'(k * 37), 5'(k * 7), 3'(k), 12'(k * 300)),
            "R1 field packing", last_addr, exp_addr(8'(k * 37), 5'(k * 7), 3'(k), 12'(k * 300)));
    end

    // R4 writes are retried regardless of visibility
    for (int nc = 0; nc < 4; nc++) begin
      run_req(1'b1, 8'd2, 5'd1, 3'd0, 12'h010, 2'd2, 32'hC0DE_0000 + 32'(nc),
              1'(nc & 1), nc, 3'd0);
      check(g_issues == nc + 1, "R4 write reissue count", 32'(g_issues), 32'(nc + 1));
      check(g_status == 2'd0 && g_data == 32'd0, "R3 write result", g_data, 32'd0);
      check(last_wr && last_wdata == 32'hC0DE_0000 + 32'(nc), "R4 write record",
            last_wdata, 32'hC0DE_0000 + 32'(nc));
    end
    run_req(1'b1, 8'd2, 5'd1, 3'd0, 12'h000, 2'd2, 32'h1, 1'b1, 2, 3'd0);
    check(g_issues == 3, "R4 visible write offset 0 retried", 32'(g_issues), 32'd3);

    // R6 synthesized vendor value
    for (int sz = 0; sz < 3; sz++)
      for (int o = 0; o < 4; o++) begin
        run_req(1'b0, 8'd9, 5'd3, 3'd1, 12'(o), 2'(sz), 32'd0, 1'b1, 3, 3'd0);
        check(g_status == 2'd0, "R6 vendor status", 32'(g_status), 32'd0);
        check(g_issues == 1, "R6 vendor single attempt", 32'(g_issues), 32'd1);
        check(g_data == exp_lane(32'hFFFF_0001, 2'(o), 2'(sz)), "R6 vendor data",
              g_data, exp_lane(32'hFFFF_0001, 2'(o), 2'(sz)));
      end
    run_req(1'b0, 8'd9, 5'd3, 3'd1, 12'h004, 2'd2, 32'd0, 1'b1, 2, 3'd0);
    check(g_issues == 3, "R4 visible other offset retried", 32'(g_issues), 32'd3);
    run_req(1'b0, 8'd9, 5'd3, 3'd1, 12'h000, 2'd2, 32'd0, 1'b0, 2, 3'd0);
    check(g_issues == 3, "R4 invisible offset 0 retried", 32'(g_issues), 32'd3);
    check(g_data == ep_data(exp_addr(8'd9, 5'd3, 3'd1, 12'h000)), "R4 real data after retry",
          g_data, ep_data(exp_addr(8'd9, 5'd3, 3'd1, 12'h000)));

    // R8 root bus
    run_req(1'b0, 8'd0, 5'd0, 3'd0, 12'h000, 2'd2, 32'd0, 1'b1, 2, 3'd0);
    check(g_status == 2'd3, "R8 root retry code", 32'(g_status), 32'd3);
    check(g_issues == 1, "R8 root no reissue", 32'(g_issues), 32'd1);
    check(last_addr[0] == 1'b0, "R1 root type bit", 32'(last_addr[0]), 32'd0);
    run_req(1'b0, 8'd0, 5'd2, 3'd0, 12'h008, 2'd2, 32'd0, 1'b0, 0, 3'd0);
    check(g_status == 2'd0 && g_data == ep_data(exp_addr(8'd0, 5'd2, 3'd0, 12'h008)),
          "R8 root normal read", g_data, ep_data(exp_addr(8'd0, 5'd2, 3'd0, 12'h008)));

    // R9 error statuses
    for (int es = 1; es < 8; es++) begin
      if (es != 2) begin
        run_req(1'b0, 8'd4, 5'd0, 3'd0, 12'h020, 2'd2, 32'd0, 1'b0, 1, 3'(es));
        check(g_status == 2'd2 && g_data == 32'd0, "R9 error completion",
              {30'd0, g_status}, 32'd2);
        check(g_issues == 2, "R9 error after one retry", 32'(g_issues), 32'd2);
      end
    end

    // R7 timeout
    run_req(1'b0, 8'd5, 5'd0, 3'd0, 12'h030, 2'd2, 32'd0, 1'b0, 100000, 3'd0);
    check(g_status == 2'd1 && g_data == 32'd0, "R7 timeout status", {30'd0, g_status}, 32'd1);
    check(g_cycles >= TMO - 2 && g_cycles <= TMO + GAP + LAT + 12, "R7 timeout window",
          32'(g_cycles), 32'(TMO));
    run_req(1'b0, 8'd5, 5'd0, 3'd0, 12'h030, 2'd2, 32'd0, 1'b0, 3, 3'd0);
    check(g_status == 2'd0, "R7 timer restarts per access", 32'(g_status), 32'd0);

    // R5 spacing after retry
    check(min_gap >= GAP + 1, "R5 retry gap", 32'(min_gap), 32'(GAP + 1));

    // R2 request while busy is ignored
    begin
      int i0;
      int n;
      @(negedge clk);
      crs_cfg = 2; ep_stat = 3'd0;
      req_valid = 1'b1; req_write = 1'b0; req_bus = 8'd7; req_dev = 5'd4;
      req_func = 3'd3; req_off = 12'h0A8; req_size = 2'd2; sw_vis_en = 1'b0;
      i0 = issues;
      @(negedge clk);
      req_bus = 8'd8; req_off = 12'h0FC;
      check(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
      repeat (6) @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      check(issues - i0 == 3, "R2 no extra request", 32'(issues - i0), 32'd3);
      check(rsp_data == ep_data(exp_addr(8'd7, 5'd4, 3'd3, 12'h0A8)), "R2 first request kept",
            rsp_data, ep_data(exp_addr(8'd7, 5'd4, 3'd3, 12'h0A8)));
      @(negedge clk);
      check(!busy, "R2 busy clears after done", 32'(busy), 32'd0);
    end

    // R11 launch and done timing
    begin
      int t0;
      int n;
      @(negedge clk);
      crs_cfg = 0; ep_stat = 3'd0;
      req_valid = 1'b1; req_bus = 8'd1; req_off = 12'h0; req_size = 2'd2;
      @(negedge clk);
      req_valid = 1'b0;
      check(!tx_valid, "R11 no pulse after first edge", 32'(tx_valid), 32'd0);
      @(negedge clk);
      check(tx_valid, "R11 pulse after second edge", 32'(tx_valid), 32'd1);
      @(negedge clk);
      check(!tx_valid, "R11 pulse one cycle", 32'(tx_valid), 32'd0);
      t0 = 0;
      n = 0;
      while (!cpl_valid && n < 50) begin @(negedge clk); n++; end
      t0 = n;
      @(negedge clk);
      check(done, "R11 done one edge after completion", 32'(done), 32'd1);
      @(negedge clk);
      check(!done && t0 < 50, "R11 done single cycle", 32'(done), 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule